// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps a small direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Bus transactions are atomic. Each line carries one of three coherence states: Invalid, Shared or Modified. Processor requests are served locally when the line's state allows it. Otherwise the block wins the bus and issues a read, a read-exclusive or a flush (write-back) transaction. At the same time the block watches the transactions of the other caches and demotes or invalidates its own copy of a line. When it holds that line Modified, it also supplies the data.

The processor holds a request, with its address, write flag and data, until `cpuReady` rises. The request completes in that cycle, and read data is valid in that same cycle. On the bus side the block raises `busReq` with a command and an address and holds them. A transaction completes in the cycle `busGnt` is high, and `busRdata` is valid in that cycle. Snooped transactions arrive on the snoop inputs, never in a cycle in which this block is granted. A flush in reply to a snoop appears on `snoopFlush`/`snoopData` in the same cycle.

The address splits into two parts. The low log2(LINES) bits select the line, and the remaining upper bits form the tag. Bus and snoop command codes are: 1 = read, 2 = read-exclusive, 3 = flush, 0 = idle.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, and `busReq`, `cpuReady` and `snoopFlush` are low. The first processor read of any address therefore requests the bus with command 1.
- R2: A processor read of a line that is not present issues command 1 and installs the line in Shared even when no other cache holds it. A later write to that line then issues command 2.
- R3: A processor write to a line that is Invalid or Shared issues command 2 (read-exclusive) and leaves the line Modified. The bus is only requested while a processor request is pending.
- R4: A read of a Shared or Modified line, and a write of a Modified line, complete in the cycle they are presented, with no bus request. A read returns the last value written to that address.
- R5: A snooped command 1 whose tag matches a Modified line raises `snoopFlush` in that cycle with the line's data on `snoopData`. The line then becomes Shared.
- R6: A snooped command 2 on a Modified line flushes it and makes it Invalid. On a Shared line it makes the line Invalid without a flush. A snooped command 3 changes nothing, and `snoopFlush` never rises without a snooped command 1 or 2.
- R7: A miss whose line holds a different tag in Modified first issues command 3 with the victim's address and data, then fetches the new line. A Shared victim is dropped with no write-back.
- R8: While a bus request waits for its grant, `cpuReady` stays low. Command and address stay unchanged as long as no snoop intervenes.
- R9: When a snoop and a processor request address the same line index in one cycle, the snoop is applied and the processor request stalls for that cycle.
- R10: When a snoop and a processor hit address different line indices in one cycle, both take effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request pending |
| cpuWrite | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Request address |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 2 | Bus command code |
| busAddr | output | ADDR_W | Bus transaction address |
| busWdata | output | DATA_W | Flush data |
| busGnt | input | 1 | Transaction completes this cycle |
| busRdata | input | DATA_W | Data from memory for read and read-exclusive |
| snoopValid | input | 1 | Another cache's transaction is on the bus |
| snoopCmd | input | 2 | Snooped command code |
| snoopAddr | input | ADDR_W | Snooped address |
| snoopFlush | output | 1 | This cache supplies the snooped line |
| snoopData | output | DATA_W | Flushed line data |

## Verification
Snoop handling and processor handling can fall in the same cycle. The bench provokes this in directed cases by presenting a snoop in the first cycle of a processor request. In one case the two share a line index and in the other they do not. A long random phase then injects snoops to a small address range alongside processor traffic and randomly withheld grants. A cycle-accurate behavioural model judges every cycle. It stalls the processor on an index clash, applies both actions otherwise, and predicts the flush and the bus outputs independently.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHD = 2'd1,
    LINE_MOD = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RD    = 2'd1,
    CMD_RDX   = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_EVICT = 2'd1,
    CT_FILL  = 2'd2
  } ctrl_state_e;

  // strobes from control to the line store
  typedef struct packed {
    logic        snpApply;
    line_state_e snpNext;
    logic        cpuWrite;
    logic        fillWrite;
    logic        fillMod;
    logic        evict;
  } line_strobe_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  line_strobe_t                  strb,
  input  logic [$clog2(LINES)-1:0]      cpuIdx,
  input  logic [ADDR_W-$clog2(LINES)-1:0] cpuTag,
  input  logic [DATA_W-1:0]             cpuWdata,
  input  logic [DATA_W-1:0]             busRdata,
  input  logic [$clog2(LINES)-1:0]      snpIdx,
  output line_state_e                   cpuState,
  output logic [ADDR_W-$clog2(LINES)-1:0] cpuLineTag,
  output logic [DATA_W-1:0]             cpuLineData,
  output line_state_e                   snpState,
  output logic [ADDR_W-$clog2(LINES)-1:0] snpLineTag,
  output logic [DATA_W-1:0]             snpLineData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_state_e       lineState [LINES];
  logic [TAG_W-1:0]  lineTag   [LINES];
  logic [DATA_W-1:0] lineData  [LINES];

  // state: fill wins over eviction, eviction over snoop (never coincide on one index)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) lineState[i] <= LINE_INV;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strb.fillWrite && cpuIdx == IDX_W'(i))
          lineState[i] <= strb.fillMod ? LINE_MOD : LINE_SHD;
        else if (strb.evict && cpuIdx == IDX_W'(i))
          lineState[i] <= LINE_INV;
        else if (strb.snpApply && snpIdx == IDX_W'(i))
          lineState[i] <= strb.snpNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (strb.fillWrite && cpuIdx == IDX_W'(i)) begin
        lineTag[i]  <= cpuTag;
        lineData[i] <= strb.fillMod ? cpuWdata : busRdata;
      end else if (strb.cpuWrite && cpuIdx == IDX_W'(i)) begin
        lineData[i] <= cpuWdata;
      end
    end
  end

  assign cpuState    = lineState[cpuIdx];
  assign cpuLineTag  = lineTag[cpuIdx];
  assign cpuLineData = lineData[cpuIdx];
  assign snpState    = lineState[snpIdx];
  assign snpLineTag  = lineTag[snpIdx];
  assign snpLineData = lineData[snpIdx];

endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cpuValid,
  input  logic                            cpuWrite,
  input  logic [$clog2(LINES)-1:0]        cpuIdx,
  input  logic [ADDR_W-$clog2(LINES)-1:0] cpuTag,
  input  line_state_e                     cpuState,
  input  logic [ADDR_W-$clog2(LINES)-1:0] cpuLineTag,
  input  logic                            snoopValid,
  input  bus_cmd_e                        snoopCmd,
  input  logic [$clog2(LINES)-1:0]        snoopIdx,
  input  logic [ADDR_W-$clog2(LINES)-1:0] snoopTag,
  input  line_state_e                     snpState,
  input  logic [ADDR_W-$clog2(LINES)-1:0] snpLineTag,
  input  logic                            busGnt,
  output line_strobe_t                    strb,
  output logic                            cpuReady,
  output logic                            busReq,
  output bus_cmd_e                        busCmd,
  output logic                            victimSel,
  output logic                            rdFromBus,
  output logic                            snoopFlush
);

  ctrl_state_e ctSt, ctNext;
  logic cpuHit, snpHit, sameIdx;

  assign cpuHit  = (cpuState != LINE_INV) && (cpuLineTag == cpuTag);
  assign snpHit  = snoopValid && (snpState != LINE_INV) && (snpLineTag == snoopTag);
  assign sameIdx = snoopValid && (snoopIdx == cpuIdx);

  // snoop reaction
  always_comb begin
    snoopFlush = 1'b0;
    strb.snpApply = 1'b0;
    strb.snpNext  = LINE_INV;
    if (snpHit) begin
      unique case (snoopCmd)
        CMD_RD: begin
          if (snpState == LINE_MOD) begin
            snoopFlush    = 1'b1;
            strb.snpApply = 1'b1;
            strb.snpNext  = LINE_SHD;
          end
        end
        CMD_RDX: begin
          snoopFlush    = (snpState == LINE_MOD);
          strb.snpApply = 1'b1;
          strb.snpNext  = LINE_INV;
        end
        default: ;
      endcase
    end
  end

  // processor side sequencing
  always_comb begin
    ctNext         = ctSt;
    cpuReady       = 1'b0;
    busReq         = 1'b0;
    busCmd         = CMD_NONE;
    victimSel      = 1'b0;
    rdFromBus      = 1'b0;
    strb.cpuWrite  = 1'b0;
    strb.fillWrite = 1'b0;
    strb.fillMod   = 1'b0;
    strb.evict     = 1'b0;
    unique case (ctSt)
      CT_IDLE: begin
        if (cpuValid && !sameIdx) begin
          if (cpuHit && (!cpuWrite || cpuState == LINE_MOD)) begin
            cpuReady      = 1'b1;
            strb.cpuWrite = cpuWrite;
          end else if (cpuHit) begin
            ctNext = CT_FILL;
          end else if (cpuState == LINE_MOD) begin
            ctNext = CT_EVICT;
          end else begin
            ctNext = CT_FILL;
          end
        end
      end
      CT_EVICT: begin
        ctNext = CT_FILL;
        if (cpuState == LINE_MOD) begin
          busReq    = 1'b1;
          busCmd    = CMD_FLUSH;
          victimSel = 1'b1;
          if (busGnt) strb.evict = 1'b1;
          else        ctNext     = CT_EVICT;
        end
      end
      CT_FILL: begin
        busReq = 1'b1;
        busCmd = cpuWrite ? CMD_RDX : CMD_RD;
        if (busGnt) begin
          strb.fillWrite = 1'b1;
          strb.fillMod   = cpuWrite;
          cpuReady       = 1'b1;
          rdFromBus      = 1'b1;
          ctNext         = CT_IDLE;
        end
      end
      default: ctNext = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctSt <= CT_IDLE;
    else       ctSt <= ctNext;
  end

endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busGnt,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snoopValid,
  input  logic [1:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopFlush,
  output logic [DATA_W-1:0] snoopData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_strobe_t      strb;
  line_state_e       cpuState, snpState;
  logic [TAG_W-1:0]  cpuLineTag, snpLineTag;
  logic [DATA_W-1:0] cpuLineData, snpLineData;
  logic [IDX_W-1:0]  cpuIdx, snoopIdx;
  logic [TAG_W-1:0]  cpuTag, snoopTag;
  logic              victimSel, rdFromBus;
  bus_cmd_e          ctBusCmd;

  assign cpuIdx   = cpuAddr[IDX_W-1:0];
  assign cpuTag   = cpuAddr[ADDR_W-1:IDX_W];
  assign snoopIdx = snoopAddr[IDX_W-1:0];
  assign snoopTag = snoopAddr[ADDR_W-1:IDX_W];

  msi_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cpuValid   (cpuValid),
    .cpuWrite   (cpuWrite),
    .cpuIdx     (cpuIdx),
    .cpuTag     (cpuTag),
    .cpuState   (cpuState),
    .cpuLineTag (cpuLineTag),
    .snoopValid (snoopValid),
    .snoopCmd   (bus_cmd_e'(snoopCmd)),
    .snoopIdx   (snoopIdx),
    .snoopTag   (snoopTag),
    .snpState   (snpState),
    .snpLineTag (snpLineTag),
    .busGnt     (busGnt),
    .strb       (strb),
    .cpuReady   (cpuReady),
    .busReq     (busReq),
    .busCmd     (ctBusCmd),
    .victimSel  (victimSel),
    .rdFromBus  (rdFromBus),
    .snoopFlush (snoopFlush)
  );

  msi_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) store_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cpuIdx      (cpuIdx),
    .cpuTag      (cpuTag),
    .cpuWdata    (cpuWdata),
    .busRdata    (busRdata),
    .snpIdx      (snoopIdx),
    .cpuState    (cpuState),
    .cpuLineTag  (cpuLineTag),
    .cpuLineData (cpuLineData),
    .snpState    (snpState),
    .snpLineTag  (snpLineTag),
    .snpLineData (snpLineData)
  );

  assign busCmd    = ctBusCmd;
  assign busAddr   = victimSel ? {cpuLineTag, cpuIdx} : cpuAddr;
  assign busWdata  = cpuLineData;
  assign cpuRdata  = rdFromBus ? busRdata : cpuLineData;
  assign snoopData = snpLineData;

endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuReady,
  input logic              busReq,
  input logic              busGnt,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              snoopValid,
  input logic [1:0]        snoopCmd,
  input logic [ADDR_W-1:0] snoopAddr,
  input logic              snoopFlush
);

  localparam int IDX_W = $clog2(LINES);

  logic sameIdx;
  assign sameIdx = cpuAddr[IDX_W-1:0] == snoopAddr[IDX_W-1:0];

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt && !snoopValid |=> busReq && $stable(busCmd) && $stable(busAddr)); // R8

  AST_STALL_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt |-> !cpuReady); // R8

  AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    snoopFlush |-> snoopValid && (snoopCmd == 2'd1 || snoopCmd == 2'd2)); // R6

  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && snoopValid && !busGnt && sameIdx |-> !cpuReady); // R9

  AST_REQ_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> cpuValid); // R3

  AST_GRANTED_FILL_READY: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGnt && busCmd != 2'd3 |-> cpuReady); // R2

endmodule

bind msi_snoop_cache msi_snoop_cache_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cpuValid   (cpuValid),
  .cpuAddr    (cpuAddr),
  .cpuReady   (cpuReady),
  .busReq     (busReq),
  .busGnt     (busGnt),
  .busCmd     (busCmd),
  .busAddr    (busAddr),
  .snoopValid (snoopValid),
  .snoopCmd   (snoopCmd),
  .snoopAddr  (snoopAddr),
  .snoopFlush (snoopFlush)
);

// File: tb/msi_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module msi_snoop_cache_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 4;

  logic          clk, rstN;
  logic          cpuValid, cpuWrite, cpuReady;
  logic [AW-1:0] cpuAddr, busAddr, snoopAddr;
  logic [DW-1:0] cpuWdata, cpuRdata, busWdata, busRdata, snoopData;
  logic          busReq, busGnt, snoopValid, snoopFlush;
  logic [1:0]    busCmd, snoopCmd;

  logic [DW-1:0] mem [256];
  assign busRdata = mem[busAddr];

  msi_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) dut_i (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busGnt(busGnt), .busRdata(busRdata),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopAddr(snoopAddr),
    .snoopFlush(snoopFlush), .snoopData(snoopData)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nChk = 0, nFail = 0;

  // behavioural model: 0 = I, 1 = S, 2 = M; mode 0 idle, 1 write-back, 2 fill
  int mst [NL], mtag [NL], mdat [NL];
  int mmode;
  int cIdx, cTg, sIdx, sTg, cState;
  bit snHit, conflict, hit;
  int eReady, eReq, eCmd, eAddr, eWd, eRd, eFlush, eFlData;

  int gntHold = 0;
  bit gntRand = 0;
  int tReady, tReq, tCmd, tAddr, tGnt, tFlush, tFlData, tRdata;
  int opFirstCmd, opFirstAddr, opBusCnt, opCycles, opReady0, opFlush0, opFlData, opRdata;

  task automatic chk(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelComb();
    cIdx = int'(cpuAddr) % NL;  cTg = int'(cpuAddr) / NL;
    sIdx = int'(snoopAddr) % NL; sTg = int'(snoopAddr) / NL;
    cState   = mst[cIdx];
    snHit    = snoopValid && mst[sIdx] != 0 && mtag[sIdx] == sTg;
    conflict = snoopValid && sIdx == cIdx;
    hit      = mst[cIdx] != 0 && mtag[cIdx] == cTg;
    eFlush   = (snHit && mst[sIdx] == 2 && (snoopCmd == 2'd1 || snoopCmd == 2'd2)) ? 1 : 0;
    eFlData  = mdat[sIdx];
    eReady = 0; eReq = 0; eCmd = 0; eAddr = 0; eWd = 0; eRd = 0;
    if (mmode == 0) begin
      if (cpuValid && !conflict && hit && (!cpuWrite || cState == 2)) begin
        eReady = 1; eRd = mdat[cIdx];
      end
    end else if (mmode == 1) begin
      if (cState == 2) begin
        eReq = 1; eCmd = 3; eAddr = mtag[cIdx] * NL + cIdx; eWd = mdat[cIdx];
      end
    end else begin
      eReq = 1; eCmd = cpuWrite ? 2 : 1; eAddr = int'(cpuAddr);
      if (busGnt) begin eReady = 1; eRd = int'(mem[cpuAddr]); end
    end
  endtask

  task automatic modelSeq();
    if (snHit) begin
      if (snoopCmd == 2'd2) mst[sIdx] = 0;
      else if (snoopCmd == 2'd1 && mst[sIdx] == 2) mst[sIdx] = 1;
    end
    if (eFlush != 0) mem[snoopAddr] = eFlData[DW-1:0];
    case (mmode)
      0: if (cpuValid && !conflict) begin
           if (eReady != 0) begin
             if (cpuWrite) mdat[cIdx] = int'(cpuWdata);
           end else if (hit) mmode = 2;
           else if (cState == 2) mmode = 1;
           else mmode = 2;
         end
      1: begin
           if (cState == 2 && busGnt) begin
             mem[eAddr[AW-1:0]] = mdat[cIdx][DW-1:0];
             mst[cIdx] = 0;
             mmode = 2;
           end else if (cState != 2) mmode = 2;
         end
      default: if (busGnt) begin
           mtag[cIdx] = cTg;
           mst[cIdx]  = cpuWrite ? 2 : 1;
           mdat[cIdx] = cpuWrite ? int'(cpuWdata) : int'(mem[cpuAddr]);
           mmode = 0;
         end
    endcase
  endtask

  // one clock: inputs set at the falling edge, outputs compared mid-low-phase
  task automatic tick();
    bit allow;
    modelComb();
    allow = (gntHold == 0) && (!gntRand || ($urandom % 3) != 0);
    busGnt = (eReq != 0) && allow && !snoopValid;
    modelComb();
    if (gntHold > 0) gntHold--;
    #2;
    chk("R8 cpuReady", int'(cpuReady), eReady);
    if (eReady != 0 && !cpuWrite) chk("R4 cpuRdata", int'(cpuRdata), eRd);
    chk("R8 busReq", int'(busReq), eReq);
    if (eReq != 0) begin
      chk("R3 busCmd", int'(busCmd), eCmd);
      chk("R7 busAddr", int'(busAddr), eAddr);
      if (eCmd == 3) chk("R7 busWdata", int'(busWdata), eWd);
    end
    chk("R6 snoopFlush", int'(snoopFlush), eFlush);
    if (eFlush != 0) chk("R5 snoopData", int'(snoopData), eFlData);
    tReady = int'(cpuReady); tReq = int'(busReq); tCmd = int'(busCmd);
    tAddr = int'(busAddr); tGnt = int'(busGnt); tFlush = int'(snoopFlush);
    tFlData = int'(snoopData); tRdata = int'(cpuRdata);
    @(posedge clk);
    #1;
    modelSeq();
    @(negedge clk);
  endtask

  task automatic runOp(input bit w, input int a, input int d, input int sc, input int sa);
    int n = 0;
    opFirstCmd = -1; opFirstAddr = -1; opBusCnt = 0;
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = a[AW-1:0]; cpuWdata = d[DW-1:0];
    snoopValid = (sc != 0); snoopCmd = sc[1:0]; snoopAddr = sa[AW-1:0];
    do begin
      tick();
      n++;
      if (n == 1) begin opReady0 = tReady; opFlush0 = tFlush; end
      snoopValid = 1'b0;
      if (tReq != 0 && opFirstCmd < 0) begin opFirstCmd = tCmd; opFirstAddr = tAddr; end
      if (tReq != 0 && tGnt != 0) opBusCnt++;
    end while (tReady == 0 && n < 100);
    opRdata = tRdata; opCycles = n;
    cpuValid = 1'b0;
  endtask

  task automatic snoopOnly(input int sc, input int sa);
    cpuValid = 1'b0;
    snoopValid = 1'b1; snoopCmd = sc[1:0]; snoopAddr = sa[AW-1:0];
    tick();
    opFlush0 = tFlush; opFlData = tFlData;
    snoopValid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL R8 watchdog: actual hung expected run complete");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 'h100);
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mtag[i] = 0; mdat[i] = 0; end
    mmode = 0;
    rstN = 1'b0; cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    busGnt = 1'b0; snoopValid = 1'b0; snoopCmd = '0; snoopAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset busReq", int'(busReq), 0);
    chk("R1 reset cpuReady", int'(cpuReady), 0);
    chk("R1 reset snoopFlush", int'(snoopFlush), 0);
    @(negedge clk);

    // R1 / R2: miss from Invalid reads, installs Shared
    runOp(1'b0, 'h05, 0, 0, 0);
    chk("R1 first read cmd", opFirstCmd, 1);
    chk("R2 fill data", opRdata, 'h10f);
    runOp(1'b1, 'h05, 'hA5A5, 0, 0);
    chk("R2 write after read upgrades", opFirstCmd, 2);
    // R4: local hits
    runOp(1'b0, 'h05, 0, 0, 0);
    chk("R4 read hit no bus", opBusCnt, 0);
    chk("R4 read hit one cycle", opCycles, 1);
    chk("R4 read hit data", opRdata, 'hA5A5);
    runOp(1'b1, 'h05, 'h1234, 0, 0);
    chk("R4 write hit no bus", opBusCnt, 0);
    // R5: snooped read on Modified
    snoopOnly(1, 'h05);
    chk("R5 flush on snooped read", opFlush0, 1);
    chk("R5 flush data", opFlData, 'h1234);
    runOp(1'b1, 'h05, 'h2222, 0, 0);
    chk("R5 line now Shared", opFirstCmd, 2);
    // R6: snooped read-exclusive on Modified, then on Shared, then flush ignored
    snoopOnly(2, 'h05);
    chk("R6 flush on snooped rdx", opFlush0, 1);
    runOp(1'b0, 'h05, 0, 0, 0);
    chk("R6 line invalidated", opFirstCmd, 1);
    chk("R6 flushed data reached memory", opRdata, 'h2222);
    snoopOnly(2, 'h05);
    chk("R6 no flush from Shared", opFlush0, 0);
    runOp(1'b0, 'h05, 0, 0, 0);
    chk("R6 Shared invalidated", opFirstCmd, 1);
    snoopOnly(3, 'h05);
    chk("R6 snooped flush no action", opFlush0, 0);
    runOp(1'b0, 'h05, 0, 0, 0);
    chk("R6 line kept after snooped flush", opBusCnt, 0);
    // R7: Modified victim written back, Shared victim dropped
    runOp(1'b1, 'h05, 'h3333, 0, 0);
    runOp(1'b0, 'h09, 0, 0, 0);
    chk("R7 victim flush cmd", opFirstCmd, 3);
    chk("R7 victim address", opFirstAddr, 'h05);
    chk("R7 two transactions", opBusCnt, 2);
    chk("R7 victim data in memory", int'(mem[5]), 'h3333);
    runOp(1'b0, 'h0D, 0, 0, 0);
    chk("R7 Shared victim no write-back", opFirstCmd, 1);
    chk("R7 one transaction", opBusCnt, 1);
    // R8: grant withheld
    gntHold = 5;
    runOp(1'b0, 'h02, 0, 0, 0);
    chk("R8 stall length", opCycles, 6);
    // R9: same index snoop and request
    runOp(1'b1, 'h02, 'h4444, 0, 0);
    runOp(1'b0, 'h02, 0, 2, 'h02);
    chk("R9 processor stalled", opReady0, 0);
    chk("R9 snoop applied", opFlush0, 1);
    chk("R9 line lost to snoop", opFirstCmd, 1);
    chk("R9 refetched data", opRdata, 'h4444);
    // R10: different indices same cycle
    runOp(1'b1, 'h03, 'h5555, 0, 0);
    runOp(1'b1, 'h02, 'h6666, 0, 0);
    runOp(1'b0, 'h03, 0, 2, 'h02);
    chk("R10 processor served", opReady0, 1);
    chk("R10 snoop served", opFlush0, 1);
    chk("R10 read data", opRdata, 'h5555);

    // random mix of traffic, snoops and withheld grants
    gntRand = 1'b1;
    repeat (4000) begin
      if (!cpuValid && ($urandom % 2) != 0) begin
        cpuValid = 1'b1;
        cpuWrite = 1'($urandom % 2);
        cpuAddr  = AW'($urandom % 16);
        cpuWdata = DW'($urandom);
      end
      if (($urandom % 4) == 0) begin
        snoopValid = 1'b1;
        snoopCmd   = 2'(1 + $urandom % 3);
        snoopAddr  = AW'($urandom % 16);
      end else begin
        snoopValid = 1'b0;
      end
      tick();
      if (tReady != 0) cpuValid = 1'b0;
    end
    snoopValid = 1'b0;
    summary();
    $finish;
  end

endmodule